// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Unit

This block serves one processor of an interrupt controller. When the processor reads its acknowledge location, the block picks the best source from the set of sources currently raised toward that processor and checks the source again at that moment. It answers with either the source's vector or the spurious vector. In the same clock it emits one-cycle clear and update strobes. The source and destination storage that lives outside the block applies these strobes.

The choice favours the highest source priority. Ties go to the lowest source index. At acknowledge time the source must still be active, and its priority must still be strictly above the processor's task priority. If either test fails, the read is spurious and only the source's activity flag is dropped. A valid acknowledge takes the source out of the raised set and invalidates the cached best selection. For edge-triggered sources it also clears the activity and pending state. For inter-processor sources it removes this processor from the destination mask, and it re-fires the source if other processors still have to take it.

The block also tracks the best raised priority from cycle to cycle. It pulses an interrupt request only when a better source shows up, or when the cache was invalidated by a valid acknowledge.

Top module: `cpu_int_ack`

## Requirements
- R1: An acknowledge with no source raised returns the spurious vector with `ack_spurious`=1, and every clear, set, write and retrigger strobe stays 0.
- R2: The selected source is the raised source with the largest priority field; among equal priorities the lowest index wins.
- R3: If the selected source has `src_active`=0, or its priority is less than or equal to `task_prio`, the answer is spurious, `clr_active` has only that source's bit set, and `clr_raised`, `next_inval` and all other strobes stay 0.
- R4: Otherwise the answer is the source's vector with `ack_spurious`=0, `clr_raised` is one-hot on that source, and `next_inval`=1.
- R5: On a valid acknowledge of an edge source (`src_level` bit = 0) not re-fired under R7, `clr_active` and `clr_pending` are one-hot on it; for a level source (`src_level` bit = 1) both stay 0.
- R6: On a valid acknowledge of an inter-processor source (`src_ipi` bit = 1), `dest_wr` is one-hot on it and `dest_new` equals its destination mask with bit `MY_CPU` cleared (bit c of a mask stands for processor c).
- R7: If an R6 source is edge and `dest_new` is nonzero, `retrig` and `set_active` are one-hot on it and `clr_active` and `clr_pending` stay 0.
- R8: Results and strobes are valid exactly in the cycle after a clock edge that samples `ack_req`=1, last one cycle, and are all 0 otherwise.
- R9: `int_pulse` is 1 for one cycle after an edge where some source is raised and either no best priority is cached or the best raised priority exceeds the cached one. A newly raised source of lower or equal priority gives no pulse, and a valid acknowledge clears the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_req | input | 1 | Acknowledge read strobe |
| raised | input | N_SRC | Sources raised toward this processor |
| src_prio | input | N_SRC*PRIO_W | Per-source priority, source i at bits i*PRIO_W |
| src_vec | input | N_SRC*VEC_W | Per-source vector |
| src_active | input | N_SRC | Per-source activity flag |
| src_level | input | N_SRC | 1 = level-triggered, 0 = edge-triggered |
| src_ipi | input | N_SRC | 1 = inter-processor source |
| src_dest | input | N_SRC*N_CPU | Per-source destination mask |
| task_prio | input | PRIO_W | Current task priority of this processor |
| spur_vec | input | VEC_W | Spurious vector |
| ack_valid | output | 1 | Acknowledge answer valid |
| ack_spurious | output | 1 | Answer is the spurious vector |
| ack_vec | output | VEC_W | Returned vector |
| clr_raised | output | N_SRC | Remove source from raised set |
| clr_active | output | N_SRC | Clear source activity flag |
| set_active | output | N_SRC | Set source activity flag |
| clr_pending | output | N_SRC | Clear source pending flag |
| retrig | output | N_SRC | Re-fire source toward remaining processors |
| dest_wr | output | N_SRC | Write destination mask of source |
| dest_new | output | N_CPU | New destination mask value |
| next_inval | output | 1 | Invalidate cached next-source choice |
| int_pulse | output | 1 | New better interrupt available |

## Verification
The assertions assume that the source fields and `spur_vec` hold steady from the acknowledge edge to the answer. They also assume that every source index the selector can return is present in the per-source inputs. The bench changes its inputs only on falling edges and holds them through each acknowledge. It sweeps every raised pattern, every task priority and several priority, activity, trigger-type and destination patterns on a four-source, two-processor configuration. A directed sequence raises sources of lower, equal and higher priority to exercise the pulse cache.

// File: rtl/cpu_int_ack_pkg.sv
package cpu_int_ack_pkg;
    typedef enum logic [1:0] {
        ACK_IDLE = 2'd0,
        ACK_NONE = 2'd1,
        ACK_SPUR = 2'd2,
        ACK_OK   = 2'd3
    } ack_kind_e;
endpackage

// File: rtl/cpu_int_ack_sel.sv
module cpu_int_ack_sel #(
    parameter int N_SRC  = 4,
    parameter int PRIO_W = 3,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0]        raised,
    input  logic [N_SRC*PRIO_W-1:0] prio_flat,
    output logic                    any,
    output logic [IDX_W-1:0]        idx,
    output logic [PRIO_W-1:0]       prio
);
    // Ascending scan with strict compare keeps the lowest index on ties.
    always_comb begin
        any  = 1'b0;
        idx  = '0;
        prio = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (raised[i] && (!any || prio_flat[i*PRIO_W +: PRIO_W] > prio)) begin
                any  = 1'b1;
                idx  = IDX_W'(i);
                prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/cpu_int_ack.sv
module cpu_int_ack
    import cpu_int_ack_pkg::*;
#(
    parameter int N_SRC  = 4,
    parameter int N_CPU  = 2,
    parameter int PRIO_W = 3,
    parameter int VEC_W  = 8,
    parameter int MY_CPU = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ack_req,
    input  logic [N_SRC-1:0]        raised,
    input  logic [N_SRC*PRIO_W-1:0] src_prio,
    input  logic [N_SRC*VEC_W-1:0]  src_vec,
    input  logic [N_SRC-1:0]        src_active,
    input  logic [N_SRC-1:0]        src_level,
    input  logic [N_SRC-1:0]        src_ipi,
    input  logic [N_SRC*N_CPU-1:0]  src_dest,
    input  logic [PRIO_W-1:0]       task_prio,
    input  logic [VEC_W-1:0]        spur_vec,
    output logic                    ack_valid,
    output logic                    ack_spurious,
    output logic [VEC_W-1:0]        ack_vec,
    output logic [N_SRC-1:0]        clr_raised,
    output logic [N_SRC-1:0]        clr_active,
    output logic [N_SRC-1:0]        set_active,
    output logic [N_SRC-1:0]        clr_pending,
    output logic [N_SRC-1:0]        retrig,
    output logic [N_SRC-1:0]        dest_wr,
    output logic [N_CPU-1:0]        dest_new,
    output logic                    next_inval,
    output logic                    int_pulse
);
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam logic [N_CPU-1:0] MY_BIT = N_CPU'(1) << MY_CPU;

    typedef struct packed {
        logic              ack_valid;
        logic              spurious;
        logic [VEC_W-1:0]  vec;
        logic [N_SRC-1:0]  clr_raised;
        logic [N_SRC-1:0]  clr_active;
        logic [N_SRC-1:0]  set_active;
        logic [N_SRC-1:0]  clr_pending;
        logic [N_SRC-1:0]  retrig;
        logic [N_SRC-1:0]  dest_wr;
        logic [N_CPU-1:0]  dest_new;
        logic              next_inval;
        logic              best_valid;
        logic [PRIO_W-1:0] best_prio;
        logic              int_pulse;
    } state_t;

    state_t st_d, st_q;

    // Per-source fields unpacked for indexing by the selected source.
    logic [VEC_W-1:0] vec_a  [N_SRC];
    logic [N_CPU-1:0] dest_a [N_SRC];

    for (genvar g = 0; g < N_SRC; g++) begin : g_unpack
        assign vec_a[g]  = src_vec[g*VEC_W +: VEC_W];
        assign dest_a[g] = src_dest[g*N_CPU +: N_CPU];
    end

    logic              sel_any;
    logic [IDX_W-1:0]  sel_idx;
    logic [PRIO_W-1:0] sel_prio;

    cpu_int_ack_sel #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_sel (
        .raised    (raised),
        .prio_flat (src_prio),
        .any       (sel_any),
        .idx       (sel_idx),
        .prio      (sel_prio)
    );

    ack_kind_e        kind;
    logic [N_SRC-1:0] sel_oh;
    logic [N_CPU-1:0] remain;

    always_comb begin
        sel_oh = N_SRC'(1) << sel_idx;
        remain = dest_a[sel_idx] & ~MY_BIT;

        if (!ack_req)
            kind = ACK_IDLE;
        else if (!sel_any)
            kind = ACK_NONE;
        else if (!src_active[sel_idx] || sel_prio <= task_prio)
            kind = ACK_SPUR;
        else
            kind = ACK_OK;

        st_d            = '0;
        st_d.best_valid = sel_any;
        st_d.best_prio  = sel_prio;
        st_d.int_pulse  = sel_any && (!st_q.best_valid || sel_prio > st_q.best_prio);

        unique case (kind)
            ACK_IDLE: ;
            ACK_NONE: begin
                st_d.ack_valid = 1'b1;
                st_d.spurious  = 1'b1;
                st_d.vec       = spur_vec;
            end
            ACK_SPUR: begin
                st_d.ack_valid  = 1'b1;
                st_d.spurious   = 1'b1;
                st_d.vec        = spur_vec;
                st_d.clr_active = sel_oh;
            end
            ACK_OK: begin
                st_d.ack_valid  = 1'b1;
                st_d.vec        = vec_a[sel_idx];
                st_d.clr_raised = sel_oh;
                st_d.next_inval = 1'b1;
                st_d.best_valid = 1'b0;
                if (src_ipi[sel_idx]) begin
                    st_d.dest_wr  = sel_oh;
                    st_d.dest_new = remain;
                end
                if (!src_level[sel_idx]) begin
                    if (src_ipi[sel_idx] && (|remain)) begin
                        st_d.retrig     = sel_oh;
                        st_d.set_active = sel_oh;
                    end else begin
                        st_d.clr_active  = sel_oh;
                        st_d.clr_pending = sel_oh;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign ack_valid    = st_q.ack_valid;
    assign ack_spurious = st_q.spurious;
    assign ack_vec      = st_q.vec;
    assign clr_raised   = st_q.clr_raised;
    assign clr_active   = st_q.clr_active;
    assign set_active   = st_q.set_active;
    assign clr_pending  = st_q.clr_pending;
    assign retrig       = st_q.retrig;
    assign dest_wr      = st_q.dest_wr;
    assign dest_new     = st_q.dest_new;
    assign next_inval   = st_q.next_inval;
    assign int_pulse    = st_q.int_pulse;

    // R8: an answer only follows a sampled request.
    a_r8_answer_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(ack_req));

    // R8: no strobe without an answer.
    a_r8_no_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_valid |-> (clr_raised == '0 && clr_active == '0 && set_active == '0
                        && clr_pending == '0 && retrig == '0 && dest_wr == '0 && !next_inval));

    // R4: at most one source leaves the raised set per acknowledge.
    a_r4_single_removal: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_raised));

    // R1 / R3: a spurious answer carries the spurious vector and removes nothing.
    a_r3_spurious_keeps_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_spurious) |-> (ack_vec == $past(spur_vec)
                                         && clr_raised == '0 && !next_inval));

    // R4: removal only on a non-spurious answer.
    a_r4_removal_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_raised) |-> (ack_valid && !ack_spurious && next_inval));

    // R7: a re-fire restores activity, keeps pending and rewrites the mask.
    a_r7_refire_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (|retrig) |-> (set_active == retrig && clr_pending == '0 && dest_wr == retrig
                       && dest_new != '0));

    // R5: activity is never both set and cleared.
    a_r5_active_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_active & set_active) == '0);

    // R9: a pulse needs a raised source on the previous edge.
    a_r9_pulse_needs_raise: assert property (@(posedge clk) disable iff (!rst_n)
        int_pulse |-> $past(|raised));
endmodule

// File: tb/tb_cpu_int_ack.sv
module tb_cpu_int_ack;
    localparam int NS = 4;
    localparam int NC = 2;
    localparam int PW = 3;
    localparam int VW = 8;
    localparam int ME = 0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ack_req = 1'b0;
    logic [NS-1:0]     raised = '0;
    logic [NS*PW-1:0]  src_prio = '0;
    logic [NS*VW-1:0]  src_vec = '0;
    logic [NS-1:0]     src_active = '0;
    logic [NS-1:0]     src_level = '0;
    logic [NS-1:0]     src_ipi = '0;
    logic [NS*NC-1:0]  src_dest = '0;
    logic [PW-1:0]     task_prio = '0;
    logic [VW-1:0]     spur_vec = 8'hFF;

    logic              ack_valid, ack_spurious, next_inval, int_pulse;
    logic [VW-1:0]     ack_vec;
    logic [NS-1:0]     clr_raised, clr_active, set_active, clr_pending, retrig, dest_wr;
    logic [NC-1:0]     dest_new;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cpu_int_ack #(.N_SRC(NS), .N_CPU(NC), .PRIO_W(PW), .VEC_W(VW), .MY_CPU(ME)) dut (
        .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .raised(raised),
        .src_prio(src_prio), .src_vec(src_vec), .src_active(src_active),
        .src_level(src_level), .src_ipi(src_ipi), .src_dest(src_dest),
        .task_prio(task_prio), .spur_vec(spur_vec),
        .ack_valid(ack_valid), .ack_spurious(ack_spurious), .ack_vec(ack_vec),
        .clr_raised(clr_raised), .clr_active(clr_active), .set_active(set_active),
        .clr_pending(clr_pending), .retrig(retrig), .dest_wr(dest_wr),
        .dest_new(dest_new), .next_inval(next_inval), .int_pulse(int_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] prio_of(input int i);
        return src_prio[i*PW +: PW];
    endfunction

    // Expected answer computed from the requirements.
    task automatic check_answer();
        int best = -1;
        logic [NS-1:0] oh, e_cr, e_ca, e_sa, e_cp, e_rt, e_dw;
        logic [NC-1:0] e_dn, rem;
        logic [VW-1:0] e_vec;
        logic e_sp, e_ni;
        string t;
        for (int i = 0; i < NS; i++)
            if (raised[i] && (best < 0 || prio_of(i) > prio_of(best))) best = i;
        {e_cr, e_ca, e_sa, e_cp, e_rt, e_dw, e_dn, e_ni} = '0;
        e_sp = 1'b1; e_vec = spur_vec;
        if (best < 0) begin
            t = "R1";
        end else begin
            oh = NS'(1) << best;
            if (!src_active[best] || prio_of(best) <= task_prio) begin
                t = "R3"; e_ca = oh;
            end else begin
                t = "R2/R4"; e_sp = 1'b0; e_vec = src_vec[best*VW +: VW];
                e_cr = oh; e_ni = 1'b1;
                rem = src_dest[best*NC +: NC] & ~(NC'(1) << ME);
                if (src_ipi[best]) begin e_dw = oh; e_dn = rem; end
                if (!src_level[best]) begin
                    if (src_ipi[best] && rem != '0) begin e_rt = oh; e_sa = oh; end
                    else begin e_ca = oh; e_cp = oh; end
                end
            end
        end
        chk("R8 ack_valid", 32'(ack_valid), 32'd1);
        chk({t, " spurious"}, 32'(ack_spurious), 32'(e_sp));
        chk({t, " vector"}, 32'(ack_vec), 32'(e_vec));
        chk({t, " clr_raised"}, 32'(clr_raised), 32'(e_cr));
        chk({t, " next_inval"}, 32'(next_inval), 32'(e_ni));
        chk("R3/R5 clr_active", 32'(clr_active), 32'(e_ca));
        chk("R5 clr_pending", 32'(clr_pending), 32'(e_cp));
        chk("R7 retrig", 32'(retrig), 32'(e_rt));
        chk("R7 set_active", 32'(set_active), 32'(e_sa));
        chk("R6 dest_wr", 32'(dest_wr), 32'(e_dw));
        chk("R6 dest_new", 32'(dest_new), 32'(e_dn));
    endtask

    task automatic check_quiet();
        chk("R8 idle outputs", 32'({ack_valid, clr_raised, clr_active, set_active,
                                    clr_pending, retrig, dest_wr, next_inval}), 32'd0);
    endtask

    task automatic set_prios(input int pp);
        int p [4];
        case (pp)
            0: p = '{3, 3, 3, 3};
            1: p = '{1, 4, 2, 6};
            2: p = '{7, 0, 7, 2};
            default: p = '{2, 5, 5, 1};
        endcase
        for (int i = 0; i < NS; i++) src_prio[i*PW +: PW] = PW'(p[i]);
    endtask

    initial begin
        for (int i = 0; i < NS; i++) src_vec[i*VW +: VW] = VW'(8'h40 + i);
        // Source 0: both CPUs, source 1: CPU1, source 2: only this CPU, source 3: both.
        src_dest = {2'b11, 2'b01, 2'b10, 2'b11};
        src_ipi  = 4'b1101;
        repeat (3) @(negedge clk);
        chk("R8 reset ack_valid", 32'(ack_valid), 32'd0);
        chk("R9 reset int_pulse", 32'(int_pulse), 32'd0);
        rst_n = 1'b1;

        // R9: cache behaviour of the interrupt pulse.
        @(negedge clk);
        src_active = '1;
        set_prios(1);
        src_prio[0 +: PW] = 3'd5; src_prio[PW +: PW] = 3'd3;
        src_prio[2*PW +: PW] = 3'd5; src_prio[3*PW +: PW] = 3'd7;
        raised = 4'b0001;
        @(negedge clk); chk("R9 first raise pulses", 32'(int_pulse), 32'd1);
        @(negedge clk); chk("R9 pulse lasts one cycle", 32'(int_pulse), 32'd0);
        raised = 4'b0011;
        @(negedge clk); chk("R9 lower priority no pulse", 32'(int_pulse), 32'd0);
        raised = 4'b0111;
        @(negedge clk); chk("R9 equal priority no pulse", 32'(int_pulse), 32'd0);
        raised = 4'b1111;
        @(negedge clk); chk("R9 higher priority pulses", 32'(int_pulse), 32'd1);
        task_prio = 3'd0; src_level = 4'b0000;
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
        chk("R4 directed vector", 32'(ack_vec), 32'h43);
        chk("R9 no pulse at ack edge", 32'(int_pulse), 32'd0);
        @(negedge clk); chk("R9 pulse after cache cleared", 32'(int_pulse), 32'd1);

        // Sweep of raised pattern, task priority and source configuration.
        for (int m = 0; m < 2; m++)
            for (int pp = 0; pp < 4; pp++)
                for (int av = 0; av < 4; av++)
                    for (int tp = 0; tp < 8; tp++)
                        for (int r = 0; r < 16; r++) begin
                            @(negedge clk);
                            src_level  = (m != 0) ? 4'b1010 : 4'b0101;
                            set_prios(pp);
                            case (av)
                                0: src_active = 4'hF;
                                1: src_active = 4'hA;
                                2: src_active = 4'h5;
                                default: src_active = 4'hE;
                            endcase
                            task_prio = PW'(tp);
                            raised    = NS'(r);
                            ack_req   = 1'b1;
                            @(negedge clk);
                            ack_req = 1'b0;
                            check_answer();
                            @(negedge clk);
                            check_quiet();
                        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule